// File: doc/BRIEF.md
# Battery Monitor Register Front End

This block is the register layer of a battery monitor that sits behind a byte-wide host bus. The bus layer upstream handles framing and acknowledge signalling. It hands this block one data byte at a time with a register address, and a strobe that marks the end of each transfer. The block gathers two bytes, high byte first, into a 16-bit word. It writes that word into the addressed register only when the transfer ends with exactly two bytes received.

There are six registers. Three are read-only. The state-of-charge and cell-voltage words come from an external estimator. The version word is a build-time constant. The other three can be written: mode, configuration and command. Two data patterns act as commands and are not stored:
- Writing 0x4000 to the mode register requests a restart of the charge estimate.
- Writing 0x0054 to the command register performs a full soft reset. This reset fires on the cycle the low byte arrives, before the transfer ends, and the transfer then gets no acknowledge.

A dedicated restart pin can also request a restart. It is synchronized and edge-detected, and it produces the same one-cycle request as the software write.

Top module: `gauge_regs_top`

## Requirements
- R1: After rst_ni is released, configuration reads CFG_RST (default 0x971C), mode and command read 0x0000, and ack_o, quick_start_o and soft_rst_o are low.
- R2: A transfer of exactly two bytes (high byte, then low byte) to a writable register is stored when eot_i is seen, and reading that address then returns the word.
- R3: A transfer that ends after one byte or after three or more bytes leaves every register unchanged and gives no acknowledge.
- R4: ack_o is high for exactly the one cycle after the eot_i cycle of a transfer that carried exactly two bytes, and at no other time.
- R5: Writes to state of charge (0x04), cell voltage (0x02) and version (0x08) are ignored. Those addresses read soc_i, vcell_i and VERSION_VAL.
- R6: Any address other than 0x02, 0x04, 0x06, 0x08, 0x0C and 0xFE reads 0x0000, and writes to it change no register.
- R7: A complete write of 0x4000 to mode (0x06) makes quick_start_o high for one cycle, in the cycle after eot_i. The stored mode value is left as it was.
- R8: A rising edge on qstrt_i makes quick_start_o high for exactly one cycle, three clock edges after the edge is sampled. Holding qstrt_i high does not produce a second pulse.
- R9: When the low byte 0x54 arrives after the high byte 0x00 at command (0xFE), soft_rst_o pulses in the next cycle and configuration, mode and command return to their reset values. The eot_i that closes that transfer produces no ack_o.
- R10: Any command word other than 0x0054, and any mode word other than 0x4000, is stored and can be read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| byte_vld_i | input | 1 | A data byte is present this cycle |
| byte_i | input | 8 | Data byte, high byte first |
| addr_i | input | 8 | Register address, used for writes and for the read mux |
| eot_i | input | 1 | End of the current transfer |
| qstrt_i | input | 1 | Asynchronous restart pin |
| soc_i | input | 16 | State-of-charge word from the estimator |
| vcell_i | input | 16 | Cell-voltage word from the estimator |
| rd_data_o | output | 16 | Word at addr_i; 0 for reserved addresses |
| ack_o | output | 1 | One-cycle pulse for a completed two-byte write |
| quick_start_o | output | 1 | One-cycle request to restart the charge estimate |
| soft_rst_o | output | 1 | One-cycle pulse after a soft reset command |

## Verification
The bench sends transfers cut short at one byte and transfers padded to three bytes. A design that counted bytes loosely would store those words and raise ack_o. It sends the reset command and checks two things in the middle of the transfer: that the reset happens on the low byte, and that the following eot_i stays silent. A design that waited for the end strobe, or acknowledged anyway, fails there. It also holds the restart pin high over many cycles to catch level-sensitive detection, and it writes the restart word to mode to confirm that the word triggers a request and is not stored.

// File: rtl/gauge_pkg.sv
package gauge_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_VCELL = 8'h02;
  localparam logic [ADDR_W-1:0] A_SOC   = 8'h04;
  localparam logic [ADDR_W-1:0] A_MODE  = 8'h06;
  localparam logic [ADDR_W-1:0] A_VER   = 8'h08;
  localparam logic [ADDR_W-1:0] A_CFG   = 8'h0C;
  localparam logic [ADDR_W-1:0] A_CMD   = 8'hFE;

  localparam logic [WORD_W-1:0] QS_WORD  = 16'h4000;
  localparam logic [WORD_W-1:0] RST_WORD = 16'h0054;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_SOC, SEL_VCELL, SEL_MODE, SEL_VER, SEL_CFG, SEL_CMD
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    case (a)
      A_SOC:   return SEL_SOC;
      A_VCELL: return SEL_VCELL;
      A_MODE:  return SEL_MODE;
      A_VER:   return SEL_VER;
      A_CFG:   return SEL_CFG;
      A_CMD:   return SEL_CMD;
      default: return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gauge_byte_asm.sv
module gauge_byte_asm
  import gauge_pkg::*;
#(
  parameter int BW = BYTE_W,
  parameter int AW = ADDR_W,
  localparam int WW = 2 * BW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          byte_vld_i,
  input  logic [BW-1:0] byte_i,
  input  logic [AW-1:0] addr_i,
  input  logic          eot_i,
  output logic [AW-1:0] addr_o,
  output logic [WW-1:0] word_o,
  output logic [WW-1:0] live_word_o,
  output logic          second_o,
  output logic          commit_o
);
  // 0: idle, 1: high byte held, 2: full word, 3: overrun
  logic [1:0]    cnt_q;
  logic [BW-1:0] hi_q;
  logic [AW-1:0] addr_q;
  logic [WW-1:0] word_q;
  logic          take;

  assign take        = byte_vld_i && !eot_i;
  assign second_o    = take && (cnt_q == 2'd1);
  assign live_word_o = {hi_q, byte_i};
  assign commit_o    = eot_i && (cnt_q == 2'd2) && !clr_i;
  assign addr_o      = addr_q;
  assign word_o      = word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i || eot_i) begin
      cnt_q <= '0;
    end else if (take && cnt_q != 2'd3) begin
      cnt_q <= cnt_q + 2'd1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= '0;
      addr_q <= '0;
      word_q <= '0;
    end else if (take) begin
      if (cnt_q == 2'd0) begin
        hi_q   <= byte_i;
        addr_q <= addr_i;
      end
      if (cnt_q == 2'd1) word_q <= {hi_q, byte_i};
    end
  end

  AST_EOT_CLEARS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eot_i |=> (cnt_q == 2'd0)); // R3
endmodule

// File: rtl/gauge_cmd_dec.sv
module gauge_cmd_dec
  import gauge_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int AW = ADDR_W,
  parameter int WW = WORD_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          commit_i,
  input  logic          second_i,
  input  logic [AW-1:0] addr_i,
  input  logic [WW-1:0] word_i,
  input  logic [WW-1:0] live_word_i,
  input  logic          qstrt_i,
  output logic          store_en_o,
  output logic          rst_req_o,
  output logic          quick_start_o,
  output logic          soft_rst_o
);
  logic [SYNC_STAGES:0] sync_q;  // extra top bit holds previous synced value
  logic                 pin_edge;
  logic                 sw_qs;
  logic                 qs_q;
  logic                 srst_q;

  assign sw_qs      = commit_i && (addr_i == A_MODE) && (word_i == QS_WORD);
  assign store_en_o = commit_i && !sw_qs;
  assign rst_req_o  = second_i && (addr_i == A_CMD) && (live_word_i == RST_WORD);

  generate
    for (genvar s = 0; s <= SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[s] <= 1'b0;
        else if (s == 0) sync_q[s] <= qstrt_i;
        else sync_q[s] <= sync_q[s-1];
      end
    end
  endgenerate

  assign pin_edge = sync_q[SYNC_STAGES-1] && !sync_q[SYNC_STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qs_q   <= 1'b0;
      srst_q <= 1'b0;
    end else begin
      qs_q   <= (sw_qs || pin_edge) && !rst_req_o;
      srst_q <= rst_req_o;
    end
  end

  assign quick_start_o = qs_q;
  assign soft_rst_o    = srst_q;

  AST_SW_QS_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && addr_i == A_MODE && word_i == QS_WORD) |=> quick_start_o); // R7
  AST_RST_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> soft_rst_o); // R9
  AST_RST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> !soft_rst_o); // R9
endmodule

// File: rtl/gauge_regfile.sv
module gauge_regfile
  import gauge_pkg::*;
#(
  parameter int             AW          = ADDR_W,
  parameter int             WW          = WORD_W,
  parameter logic [WW-1:0]  VERSION_VAL = 16'h0003,
  parameter logic [WW-1:0]  CFG_RST     = 16'h971C,
  localparam int            N_RW        = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [WW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic [WW-1:0] soc_i,
  input  logic [WW-1:0] vcell_i,
  output logic [WW-1:0] rd_data_o
);
  localparam logic [AW-1:0] RW_ADDR [N_RW] = '{A_MODE, A_CFG, A_CMD};
  localparam logic [WW-1:0] RW_RST  [N_RW] = '{'0, CFG_RST, '0};

  logic [WW-1:0] rw_q [N_RW];

  generate
    for (genvar i = 0; i < N_RW; i++) begin : g_rw
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rw_q[i] <= RW_RST[i];
        else if (clr_i) rw_q[i] <= RW_RST[i];
        else if (wr_en_i && wr_addr_i == RW_ADDR[i]) rw_q[i] <= wr_data_i;
      end
    end
  endgenerate

  always_comb begin
    unique case (decode_addr(rd_addr_i))
      SEL_SOC:   rd_data_o = soc_i;
      SEL_VCELL: rd_data_o = vcell_i;
      SEL_VER:   rd_data_o = VERSION_VAL;
      SEL_MODE:  rd_data_o = rw_q[0];
      SEL_CFG:   rd_data_o = rw_q[1];
      SEL_CMD:   rd_data_o = rw_q[2];
      default:   rd_data_o = '0;
    endcase
  end

  AST_RESERVED_WR_NOEFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !clr_i && decode_addr(wr_addr_i) == SEL_NONE)
      |=> ($stable(rw_q[0]) && $stable(rw_q[1]) && $stable(rw_q[2]))); // R6
  AST_RO_WR_NOEFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !clr_i && (wr_addr_i == A_VER || wr_addr_i == A_SOC || wr_addr_i == A_VCELL))
      |=> ($stable(rw_q[0]) && $stable(rw_q[1]) && $stable(rw_q[2]))); // R5
  AST_CLR_RESTORES_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (rw_q[1] == CFG_RST)); // R9
endmodule

// File: rtl/gauge_regs_top.sv
module gauge_regs_top
  import gauge_pkg::*;
#(
  parameter logic [WORD_W-1:0] VERSION_VAL = 16'h0003,
  parameter logic [WORD_W-1:0] CFG_RST     = 16'h971C,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              eot_i,
  input  logic              qstrt_i,
  input  logic [WORD_W-1:0] soc_i,
  input  logic [WORD_W-1:0] vcell_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              ack_o,
  output logic              quick_start_o,
  output logic              soft_rst_o
);
  logic [ADDR_W-1:0] wr_addr;
  logic [WORD_W-1:0] word, live_word;
  logic              second, commit, store_en, rst_req, ack_q;

  gauge_byte_asm #(.BW(BYTE_W), .AW(ADDR_W)) u_asm (
    .clk_i, .rst_ni,
    .clr_i       (rst_req),
    .byte_vld_i, .byte_i, .addr_i, .eot_i,
    .addr_o      (wr_addr),
    .word_o      (word),
    .live_word_o (live_word),
    .second_o    (second),
    .commit_o    (commit)
  );

  gauge_cmd_dec #(.SYNC_STAGES(SYNC_STAGES), .AW(ADDR_W), .WW(WORD_W)) u_dec (
    .clk_i, .rst_ni,
    .commit_i      (commit),
    .second_i      (second),
    .addr_i        (wr_addr),
    .word_i        (word),
    .live_word_i   (live_word),
    .qstrt_i,
    .store_en_o    (store_en),
    .rst_req_o     (rst_req),
    .quick_start_o,
    .soft_rst_o
  );

  gauge_regfile #(.AW(ADDR_W), .WW(WORD_W), .VERSION_VAL(VERSION_VAL), .CFG_RST(CFG_RST)) u_rf (
    .clk_i, .rst_ni,
    .clr_i     (rst_req),
    .wr_en_i   (store_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (word),
    .rd_addr_i (addr_i),
    .soc_i, .vcell_i,
    .rd_data_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else ack_q <= commit;
  end
  assign ack_o = ack_q;

  AST_ACK_AFTER_EOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(eot_i)); // R4
  AST_ACK_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o); // R4
  AST_RST_NO_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> !ack_o); // R9
endmodule

// File: tb/tb_gauge_regs_top.sv
module tb_gauge_regs_top;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [15:0] CFG_DEF = 16'h971C;
  localparam logic [15:0] VER_DEF = 16'h0003;
  localparam logic [15:0] SOC_V   = 16'h3A10;
  localparam logic [15:0] VCELL_V = 16'hC350;

  // {addr[8], data[16], nbytes[2], exp_ack[1], exp_read[16]}
  localparam int NV = 9;
  localparam logic [42:0] VEC [NV] = '{
    {8'h0C, 16'h1234, 2'd2, 1'b1, 16'h1234},   // R2
    {8'h0C, 16'hABCD, 2'd1, 1'b0, 16'h1234},   // R3 short
    {8'h0C, 16'h5555, 2'd3, 1'b0, 16'h1234},   // R3 overrun
    {8'h06, 16'h0001, 2'd2, 1'b1, 16'h0001},   // R10 mode
    {8'hFE, 16'h00AA, 2'd2, 1'b1, 16'h00AA},   // R10 command
    {8'h08, 16'hFFFF, 2'd2, 1'b1, VER_DEF},    // R5 version
    {8'h04, 16'h0000, 2'd2, 1'b1, SOC_V},      // R5 soc
    {8'h02, 16'h1111, 2'd2, 1'b1, VCELL_V},    // R5 vcell
    {8'h20, 16'h7777, 2'd2, 1'b1, 16'h0000}    // R6 reserved
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic byte_vld_i = 1'b0, eot_i = 1'b0, qstrt_i = 1'b0;
  logic [7:0] byte_i = '0, addr_i = '0;
  logic [15:0] rd_data_o;
  logic ack_o, quick_start_o, soft_rst_o;
  int checks = 0, fails = 0;
  logic last_ack, last_qs;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  gauge_regs_top dut (
    .clk_i, .rst_ni, .byte_vld_i, .byte_i, .addr_i, .eot_i, .qstrt_i,
    .soc_i(SOC_V), .vcell_i(VCELL_V),
    .rd_data_o, .ack_o, .quick_start_o, .soft_rst_o
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [15:0] v);
    addr_i = a; #1; v = rd_data_o;
  endtask

  // starts and ends just after a negedge
  task automatic xfer(logic [7:0] a, logic [15:0] d, int n);
    for (int i = 0; i < n; i++) begin
      byte_vld_i = 1'b1; addr_i = a;
      byte_i = (i % 2 == 1) ? d[7:0] : d[15:8];
      @(posedge clk_i); @(negedge clk_i);
    end
    byte_vld_i = 1'b0; eot_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    eot_i = 1'b0;
    last_ack = ack_o; last_qs = quick_start_o;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd(8'h0C, v); chk("R1 cfg", v, CFG_DEF);
    rd(8'h06, v); chk("R1 mode", v, 16'h0000);
    rd(8'hFE, v); chk("R1 cmd", v, 16'h0000);
    chk("R1 outs", {13'd0, ack_o, quick_start_o, soft_rst_o}, 16'h0000);

    // vector table: R2 R3 R4 R5 R6 R10
    for (int k = 0; k < NV; k++) begin
      xfer(VEC[k][42:35], VEC[k][34:19], int'(VEC[k][18:17]));
      chk("R4 ack", {15'd0, last_ack}, {15'd0, VEC[k][16]});
      @(posedge clk_i); @(negedge clk_i);
      chk("R4 ack drop", {15'd0, ack_o}, 16'h0000);
      rd(VEC[k][42:35], v); chk("R2/R3/R5/R6 read", v, VEC[k][15:0]);
    end
    rd(8'h0C, v); chk("R6 cfg untouched", v, 16'h1234);

    // R7 software quick-start, mode kept
    xfer(8'h06, 16'h4000, 2);
    chk("R7 qs pulse", {15'd0, last_qs}, 16'h0001);
    @(posedge clk_i); @(negedge clk_i);
    chk("R7 qs drop", {15'd0, quick_start_o}, 16'h0000);
    rd(8'h06, v); chk("R7 mode kept", v, 16'h0001);

    // R8 pin quick-start
    qstrt_i = 1'b1;
    repeat (2) begin @(posedge clk_i); @(negedge clk_i); end
    chk("R8 not yet", {15'd0, quick_start_o}, 16'h0000);
    @(posedge clk_i); @(negedge clk_i);
    chk("R8 pulse", {15'd0, quick_start_o}, 16'h0001);
    for (int i = 0; i < 6; i++) begin
      @(posedge clk_i); @(negedge clk_i);
      chk("R8 single", {15'd0, quick_start_o}, 16'h0000);
    end
    qstrt_i = 1'b0;

    // R9 soft reset on second byte
    xfer(8'h0C, 16'h2222, 2);
    byte_vld_i = 1'b1; addr_i = 8'hFE; byte_i = 8'h00;
    @(posedge clk_i); @(negedge clk_i);
    byte_i = 8'h54;
    @(posedge clk_i); @(negedge clk_i);
    byte_vld_i = 1'b0;
    chk("R9 srst pulse", {15'd0, soft_rst_o}, 16'h0001);
    rd(8'h0C, v); chk("R9 cfg default", v, CFG_DEF);
    rd(8'h06, v); chk("R9 mode default", v, 16'h0000);
    rd(8'hFE, v); chk("R9 cmd default", v, 16'h0000);
    eot_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    eot_i = 1'b0;
    chk("R9 no ack", {15'd0, ack_o}, 16'h0000);
    chk("R9 srst drop", {15'd0, soft_rst_o}, 16'h0000);

    // after reset the block still works
    xfer(8'hFE, 16'h0055, 2);
    chk("R10 ack", {15'd0, last_ack}, 16'h0001);
    rd(8'hFE, v); chk("R10 cmd stored", v, 16'h0055);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule